// File: doc/BRIEF.md
# Address-Range Breakpoint Watch Unit

This block watches each CPU bus cycle and compares its address and direction against a table of address-range breakpoints. Each entry holds a base address, a size and three kind bits: read, write and sticky. An enable bitmap selects the armed entries. When an armed entry sees an address inside its range, it sets its hit flag. A non-sticky entry also disarms itself, and it does so whatever the direction of the access. If the direction also matches one of the entry's kind bits, the unit raises a halt request. That request is held until the controller clears it.

Next to the table, a circular log records the program counter each time an instruction completes. On request the whole log is streamed out, oldest entry first, over a valid/ready interface. The consumer may hold `log_ready` low for any number of cycles. While it does, `log_valid`, `log_pc` and `log_last` hold their values, unless a new program counter is written into the slot being shown. A beat is transferred on each rising edge where both `log_valid` and `log_ready` are high. Entries are programmed through a simple synchronous register write port.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset, `halt_req` is 0, `hit_flags` and `arm_map` are all zero, `log_valid` is 0, and every log slot holds 0.
- R2: An entry matches only when `bus_valid` is high and the entry is armed. The address must also satisfy base <= addr < base+size, with the sum taken one bit wider so it never wraps. A size of 0 never matches.
- R3: A match sets the entry's hit flag on the next edge, whatever the access direction or kind bits.
- R4: A match clears the arm bit of a non-sticky entry on the next edge, even when the direction does not match. A sticky entry stays armed.
- R5: `halt_req` goes to 1 on the edge after a match whose direction is enabled (kind bit 0 for reads, kind bit 1 for writes). It stays 1 until `halt_clear` is sampled high. A new halting match in the same cycle as `halt_clear` keeps it at 1.
- R6: Several entries that match in the same cycle all update their hit and arm bits on the same edge.
- R7: A write with `cfg_we` high uses `cfg_addr` = {entry index, field[1:0]}. Field 0 loads the base and field 1 loads the size. Field 2 loads the kind bits {sticky bit 2, write bit 1, read bit 0}. Field 3 loads the arm bit from data bit 0 and clears the hit flag when data bit 1 is 1. A field 3 write takes priority over a match-driven disarm in the same cycle.
- R8: Each cycle with `bus_sync` high stores `bus_pc` into the log at the write index. The index then advances modulo the log depth.
- R9: A `rd_start` pulse while the log is idle streams all slots, beginning at the current write index so the oldest comes first. `log_last` is high on the final beat, and an unaccepted beat is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | ADDR_W | Bus cycle address |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_sync | input | 1 | An instruction completes this clock |
| bus_pc | input | ADDR_W | Program counter to log |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NUM_ENT)+2 | {entry index, field} |
| cfg_wdata | input | ADDR_W | Register write data |
| halt_clear | input | 1 | Clears the halt request |
| halt_req | output | 1 | Held halt request |
| hit_flags | output | NUM_ENT | Per-entry hit flags |
| arm_map | output | NUM_ENT | Per-entry armed bits |
| rd_start | input | 1 | Start a log readout |
| log_valid | output | 1 | Readout beat valid |
| log_ready | input | 1 | Consumer accepts beat |
| log_pc | output | ADDR_W | Logged program counter |
| log_last | output | 1 | Final beat of readout |

## Verification
The bench keeps 16 entries and 16-bit addresses. Entries 0 and 15 are both used, so the index decode is exercised at both ends. The log depth is reduced to 4, so six logged program counters are enough to wrap the write index. They also show that readout starts from the oldest slot both before and after the wrap, and that unwritten slots read as zero. The ready pattern stalls one cycle in three, which exercises the beat hold.

// File: rtl/addr_watch_pkg.sv
package addr_watch_pkg;

  typedef struct packed {
    logic sticky;
    logic on_write;
    logic on_read;
  } watch_kind_t;

  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_SIZE = 2'd1,
    FLD_KIND = 2'd2,
    FLD_CTRL = 2'd3
  } cfg_field_t;

endpackage

// File: rtl/aw_entry.sv
module aw_entry
  import addr_watch_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_base,
  input  logic              we_size,
  input  logic              we_kind,
  input  logic              we_ctrl,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  output logic              armed,
  output logic              hit,
  output logic              addr_match,
  output logic              halt_want
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] size_q;
  watch_kind_t       kind_q;
  logic [ADDR_W:0]   limit;
  logic              in_range;

  assign limit      = {1'b0, base_q} + {1'b0, size_q};
  assign in_range   = (bus_addr >= base_q) && ({1'b0, bus_addr} < limit);
  assign addr_match = bus_valid && armed && in_range;
  assign halt_want  = addr_match && (bus_write ? kind_q.on_write : kind_q.on_read);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      kind_q <= '0;
      armed  <= 1'b0;
      hit    <= 1'b0;
    end else begin
      if (addr_match) begin
        hit <= 1'b1;
        if (!kind_q.sticky) armed <= 1'b0;
      end
      if (we_base) base_q <= wdata;
      if (we_size) size_q <= wdata;
      if (we_kind) kind_q <= watch_kind_t'(wdata[2:0]);
      if (we_ctrl) begin
        armed <= wdata[0];
        if (wdata[1]) hit <= 1'b0;
      end
    end
  end

  // R3: any match raises the hit flag unless a clear write lands together
  a_r3_hit_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match && !(we_ctrl && wdata[1]) |=> hit);

  // R4: non-sticky entries disarm after a match
  a_r4_nonsticky_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match && !kind_q.sticky && !we_ctrl |=> !armed);

  // R4: sticky entries keep their arm bit
  a_r4_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match && kind_q.sticky && !we_ctrl |=> armed);

  // R2: a disarmed entry without a control write stays quiet next cycle
  a_r2_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !we_ctrl |=> !addr_match);

endmodule

// File: rtl/aw_pc_log.sv
module aw_pc_log #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sync,
  input  logic [ADDR_W-1:0] bus_pc,
  input  logic              rd_start,
  output logic              log_valid,
  input  logic              log_ready,
  output logic [ADDR_W-1:0] log_pc,
  output logic              log_last
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW-1:0] LAST_CNT = IW'(DEPTH - 1);

  logic [ADDR_W-1:0] slots [DEPTH];
  logic [IW-1:0]     wr_idx;
  logic [IW-1:0]     rd_ptr;
  logic [IW-1:0]     beat_cnt;
  logic              busy;

  assign log_valid = busy;
  assign log_pc    = slots[rd_ptr];
  assign log_last  = busy && (beat_cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      wr_idx <= '0;
    end else if (bus_sync) begin
      slots[wr_idx] <= bus_pc;
      wr_idx        <= wr_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_ptr   <= '0;
      beat_cnt <= '0;
    end else if (!busy) begin
      if (rd_start) begin
        busy     <= 1'b1;
        rd_ptr   <= wr_idx;
        beat_cnt <= '0;
      end
    end else if (log_ready) begin
      rd_ptr   <= rd_ptr + 1'b1;
      beat_cnt <= beat_cnt + 1'b1;
      if (beat_cnt == LAST_CNT) busy <= 1'b0;
    end
  end

  // R9: a stalled beat stays offered
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && !log_ready |=> log_valid);

  // R9: a stalled beat keeps its data when no new value is logged
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && !log_ready && !bus_sync |=> $stable(log_pc) && $stable(log_last));

  // R9: the stream ends right after its last beat is taken
  a_r9_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    log_last && log_ready |=> !log_valid);

endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import addr_watch_pkg::*;
#(
  parameter int NUM_ENT   = 16,
  parameter int ADDR_W    = 16,
  parameter int LOG_DEPTH = 8,
  localparam int ENT_W    = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_write,
  input  logic               bus_sync,
  input  logic [ADDR_W-1:0]  bus_pc,
  input  logic               cfg_we,
  input  logic [ENT_W+1:0]   cfg_addr,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  input  logic               halt_clear,
  output logic               halt_req,
  output logic [NUM_ENT-1:0] hit_flags,
  output logic [NUM_ENT-1:0] arm_map,
  input  logic               rd_start,
  output logic               log_valid,
  input  logic               log_ready,
  output logic [ADDR_W-1:0]  log_pc,
  output logic               log_last
);

  logic [ENT_W-1:0]   sel_idx;
  cfg_field_t         sel_fld;
  logic [NUM_ENT-1:0] match_vec;
  logic [NUM_ENT-1:0] halt_vec;
  logic               any_halt;

  assign sel_idx  = cfg_addr[ENT_W+1:2];
  assign sel_fld  = cfg_field_t'(cfg_addr[1:0]);
  assign any_halt = |halt_vec;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic hit_me;
    assign hit_me = cfg_we && (sel_idx == ENT_W'(g));
    aw_entry #(.ADDR_W(ADDR_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_base    (hit_me && sel_fld == FLD_BASE),
      .we_size    (hit_me && sel_fld == FLD_SIZE),
      .we_kind    (hit_me && sel_fld == FLD_KIND),
      .we_ctrl    (hit_me && sel_fld == FLD_CTRL),
      .wdata      (cfg_wdata),
      .bus_valid  (bus_valid),
      .bus_addr   (bus_addr),
      .bus_write  (bus_write),
      .armed      (arm_map[g]),
      .hit        (hit_flags[g]),
      .addr_match (match_vec[g]),
      .halt_want  (halt_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          halt_req <= 1'b0;
    else if (any_halt)   halt_req <= 1'b1;
    else if (halt_clear) halt_req <= 1'b0;
  end

  aw_pc_log #(.ADDR_W(ADDR_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sync  (bus_sync),
    .bus_pc    (bus_pc),
    .rd_start  (rd_start),
    .log_valid (log_valid),
    .log_ready (log_ready),
    .log_pc    (log_pc),
    .log_last  (log_last)
  );

  // R5: a halting match raises the request on the next edge
  a_r5_halt_set: assert property (@(posedge clk) disable iff (!rst_n)
    any_halt |=> halt_req);

  // R5: the request holds until cleared
  a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !halt_clear |=> halt_req);

  // R5: a clear with no new halting match drops the request
  a_r5_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clear && !any_halt |=> !halt_req);

  // R2: no entry matches on an idle bus
  a_r2_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> match_vec == '0);

endmodule

// File: tb/addr_watch_unit_tb_top.sv
module addr_watch_unit_tb_top;

  localparam int N  = 16;
  localparam int AW = 16;
  localparam int LD = 4;
  localparam int EW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_write = 1'b0;
  logic bus_sync = 1'b0;
  logic [AW-1:0] bus_pc = '0;
  logic cfg_we = 1'b0;
  logic [EW+1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic halt_clear = 1'b0;
  logic halt_req;
  logic [N-1:0] hit_flags, arm_map;
  logic rd_start = 1'b0;
  logic log_valid, log_last;
  logic log_ready = 1'b0;
  logic [AW-1:0] log_pc;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [AW:0] exp_q [$];

  always #4 clk = ~clk;

  addr_watch_unit #(.NUM_ENT(N), .ADDR_W(AW), .LOG_DEPTH(LD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_sync(bus_sync), .bus_pc(bus_pc),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .halt_clear(halt_clear), .halt_req(halt_req), .hit_flags(hit_flags),
    .arm_map(arm_map), .rd_start(rd_start), .log_valid(log_valid),
    .log_ready(log_ready), .log_pc(log_pc), .log_last(log_last)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(int idx, int fld, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {EW'(idx), 2'(fld)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(int idx, logic [AW-1:0] b, logic [AW-1:0] s, logic [2:0] k, logic arm);
    cfg(idx, 0, b);
    cfg(idx, 1, s);
    cfg(idx, 2, {13'd0, k});
    cfg(idx, 3, {15'd0, arm});
  endtask

  task automatic bus(logic [AW-1:0] a, logic wr, logic v);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_write = wr;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic clr_halt();
    @(negedge clk); halt_clear = 1'b1;
    @(negedge clk); halt_clear = 1'b0;
  endtask

  task automatic sync_pc(logic [AW-1:0] p);
    @(negedge clk); bus_sync = 1'b1; bus_pc = p;
    @(negedge clk); bus_sync = 1'b0;
  endtask

  task automatic readout(logic [AW-1:0] p0, logic [AW-1:0] p1, logic [AW-1:0] p2, logic [AW-1:0] p3);
    exp_q.push_back({1'b0, p0});
    exp_q.push_back({1'b0, p1});
    exp_q.push_back({1'b0, p2});
    exp_q.push_back({1'b1, p3});
    @(negedge clk); rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    for (int t = 0; t < 100 && exp_q.size() != 0; t++) @(negedge clk);
    chk("R9 all beats drained", 32'(exp_q.size()), 0);
    @(negedge clk);
    chk("R9 stream idle after last", {31'd0, log_valid}, 0);
  endtask

  // monitor: pops one expected beat per accepted transfer, then sets ready
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (log_valid && log_ready) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected beat actual=%0h expected=none", log_pc);
      end else begin
        chk("R9 beat pc/last order", {15'd0, log_last, log_pc}, {15'd0, exp_q.pop_front()});
      end
    end
    log_ready <= (cyc % 3) != 0;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 halt", {31'd0, halt_req}, 0);
    chk("R1 hits", {16'd0, hit_flags}, 0);
    chk("R1 arm", {16'd0, arm_map}, 0);
    chk("R1 log idle", {31'd0, log_valid}, 0);

    // R7 programming, R3/R4 wrong direction still hits and disarms
    prog(0, 16'h1000, 16'h0010, 3'b001, 1'b1);
    chk("R7 arm via ctrl", {16'd0, arm_map}, 32'h1);
    bus(16'h1005, 1'b1, 1'b1);
    chk("R5 no halt wrong dir", {31'd0, halt_req}, 0);
    chk("R3 hit wrong dir", {16'd0, hit_flags}, 32'h1);
    chk("R4 disarm wrong dir", {16'd0, arm_map}, 0);

    cfg(0, 3, 16'h3);
    chk("R7 clear hit rearm", {16'd0, hit_flags, arm_map}, 32'h0001);
    bus(16'h1005, 1'b0, 1'b1);
    chk("R5 halt on read", {31'd0, halt_req}, 1);
    chk("R4 disarm", {16'd0, arm_map}, 0);
    repeat (3) @(negedge clk);
    chk("R5 halt holds", {31'd0, halt_req}, 1);
    clr_halt();
    chk("R5 halt cleared", {31'd0, halt_req}, 0);

    // R2 boundaries, R4 sticky
    cfg(0, 3, 16'h2);
    prog(1, 16'h2000, 16'h0004, 3'b110, 1'b1);
    bus(16'h2004, 1'b1, 1'b1);
    chk("R2 upper bound exclusive", {16'd0, hit_flags}, 0);
    bus(16'h1FFF, 1'b1, 1'b1);
    chk("R2 below base", {31'd0, halt_req}, 0);
    bus(16'h2003, 1'b1, 1'b1);
    chk("R5 halt on write", {31'd0, halt_req}, 1);
    chk("R4 sticky stays armed", {16'd0, hit_flags, arm_map}, 32'h0002_0002);
    clr_halt();
    bus(16'h2000, 1'b0, 1'b1);
    chk("R5 read not enabled", {31'd0, halt_req}, 0);

    // R2 disarmed entry ignored, idle bus ignored
    prog(2, 16'h3000, 16'h0100, 3'b011, 1'b0);
    bus(16'h3010, 1'b0, 1'b1);
    chk("R2 disarmed entry", {16'd0, hit_flags, arm_map}, 32'h0002_0002);
    chk("R2 disarmed no halt", {31'd0, halt_req}, 0);
    bus(16'h2001, 1'b1, 1'b0);
    chk("R2 bus_valid low", {31'd0, halt_req}, 0);

    // R6 parallel updates
    cfg(1, 3, 16'h2);
    prog(3, 16'h4000, 16'h0020, 3'b001, 1'b1);
    prog(4, 16'h4010, 16'h0010, 3'b000, 1'b1);
    prog(15, 16'h4018, 16'h0008, 3'b110, 1'b1);
    bus(16'h4018, 1'b0, 1'b1);
    chk("R6 three hits", {16'd0, hit_flags}, 32'h8018);
    chk("R6 two disarmed", {16'd0, arm_map}, 32'h8000);
    chk("R6 halt", {31'd0, halt_req}, 1);
    clr_halt();

    // R5 set beats clear
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'h401A; bus_write = 1'b1; halt_clear = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; halt_clear = 1'b0;
    chk("R5 set wins over clear", {31'd0, halt_req}, 1);
    clr_halt();

    // R7 control write beats disarm in same cycle
    prog(5, 16'h5000, 16'h0001, 3'b000, 1'b1);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 16'h5000; bus_write = 1'b0;
    cfg_we = 1'b1; cfg_addr = {EW'(5), 2'd3}; cfg_wdata = 16'h1;
    @(negedge clk);
    bus_valid = 1'b0; cfg_we = 1'b0;
    chk("R7 ctrl wins arm", {16'd0, arm_map}, 32'h8020);
    chk("R7 hit still set", {16'd0, hit_flags}, 32'h8038);

    // R2 zero size and no wrap
    prog(6, 16'h6000, 16'h0000, 3'b011, 1'b1);
    bus(16'h6000, 1'b0, 1'b1);
    chk("R2 size zero", {16'd0, hit_flags}, 32'h8038);
    chk("R2 size zero armed", {16'd0, arm_map}, 32'h8060);
    prog(7, 16'hFFF0, 16'h0020, 3'b001, 1'b1);
    bus(16'h0005, 1'b0, 1'b1);
    chk("R2 no wrap low", {16'd0, hit_flags}, 32'h8038);
    bus(16'hFFFF, 1'b0, 1'b1);
    chk("R2 top address", {16'd0, hit_flags}, 32'h80B8);
    chk("R5 top halt", {31'd0, halt_req}, 1);
    clr_halt();

    // R8/R9 log before and after wrap
    sync_pc(16'hA000);
    sync_pc(16'hA001);
    readout(16'h0000, 16'h0000, 16'hA000, 16'hA001);
    sync_pc(16'hA002);
    sync_pc(16'hA003);
    sync_pc(16'hA004);
    sync_pc(16'hA005);
    readout(16'hA002, 16'hA003, 16'hA004, 16'hA005);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule